// File: doc/BRIEF.md
# PFC Voltage-Follower Duty Controller

This block closes the output-voltage loop of a bridgeless power-factor-correction front end that supplies the DC link of a brushless motor drive. Once per switching period it turns a speed command into a link-voltage target by scaling it with a programmable voltage constant. It compares the target with the sampled link voltage and advances an incremental PI law. The PI output is then scaled down by a correction factor built from the sampled rectified line voltage, which flattens the third-harmonic bulge that a discontinuous-mode converter puts into its input current.

The resulting duty drives one fixed-frequency gate signal that feeds both main switches, whichever half of the line cycle is active. Only the two voltages are sensed and there is no inner current loop: in discontinuous mode the input current follows the input voltage. The ADC front ends must present their conversions while `sample_o` is high. The gate drivers take `gate_o`.

Top module: `pfc_duty_ctrl`

## Requirements
- R1: The link target is `vref = (kv_i * speed_ref_i) >> 8`, saturated to 4095. `kv_i` carries 8 fractional bits.
- R2: On each strobe edge with `en_i` high, the error is `e = vref - vdc_i` and the PI state is updated as `u = u + ((kp_i*(e - e_prev) + ki_i*e) >>> 4)`, with `e_prev` then set to `e`. `kp_i` and `ki_i` carry 4 fractional bits.
- R3: The stored PI state saturates to the range 0 to `dmax_i`, using the `dmax_i` value present on the strobe edge, so the integrator cannot wind up.
- R4: The correction uses `vin_i` and the target, both captured on the strobe edge. With `ratio = (min(vin, vref) << 8) / vref` (0 when vref is 0) and `c = 256 - (ratio >> 1)`, the duty is `(u * c) >> 8`. This factor lies between one half and one.
- R5: The latched duty never exceeds the `dmax_i` seen at the sample that produced it.
- R6: The counter period is 256 clocks. `sample_o` is high during count 254. The new duty is latched on the wrap edge (count 255 to 0) and stays constant for the whole period that follows.
- R7: `gate_o` is high for the first `duty_o` counts of each period. It is the single gate signal for both switches.
- R8: While `en_i` is low, `gate_o` is low at once, and the PI state, previous error and duty are cleared.
- R9: After reset, `gate_o`, `duty_o` and `sample_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter run enable |
| speed_ref_i | input | 12 | Speed command, rpm |
| kv_i | input | 12 | Voltage constant, 8 fractional bits |
| vdc_i | input | 12 | Sampled DC-link voltage |
| vin_i | input | 12 | Sampled rectified line voltage |
| kp_i | input | 8 | Proportional gain, 4 fractional bits |
| ki_i | input | 8 | Integral gain, 4 fractional bits |
| dmax_i | input | 8 | Duty ceiling in counts |
| sample_o | output | 1 | Sample strobe, high in count 254 |
| gate_o | output | 1 | Gate signal for both switches |
| duty_o | output | 8 | Duty in force this period |

## Verification
A speed step from 1200 to 1500 rpm with the link voltage lagging the target exercises the proportional and integral paths together. A link sample of zero drives the state into the ceiling, and a full-scale link sample drives it to the floor, so saturation is told apart from ordinary tracking. A zero voltage constant exercises the correction factor of one, and line samples above the target exercise the factor of one half. Enable toggles and randomized gains, line levels and ceilings separate the clearing behaviour and the product rounding from the linear case.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned KV_FRAC = 8;
  localparam int unsigned G_FRAC  = 4;
  localparam int unsigned C_FRAC  = 8;
endpackage

// File: rtl/pfc_vref_gen.sv
module pfc_vref_gen
  import pfc_pkg::*;
#(
  parameter int unsigned SPD_W = 12,
  parameter int unsigned KV_W  = 12,
  parameter int unsigned V_W   = 12
) (
  input  logic [SPD_W-1:0] speed_i,
  input  logic [KV_W-1:0]  kv_i,
  output logic [V_W-1:0]   vref_o
);
  localparam int unsigned M_W = SPD_W + KV_W;
  localparam logic [M_W-1:0] VMAX = M_W'((1 << V_W) - 1);

  logic [M_W-1:0] scaled;

  always_comb begin
    scaled = (M_W'(kv_i) * M_W'(speed_i)) >> KV_FRAC;
    vref_o = (scaled > VMAX) ? '1 : V_W'(scaled);
  end
endmodule

// File: rtl/pfc_pi_incr.sv
module pfc_pi_incr
  import pfc_pkg::*;
#(
  parameter int unsigned V_W = 12,
  parameter int unsigned G_W = 8,
  parameter int unsigned D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           strobe_i,
  input  logic [V_W-1:0] vref_i,
  input  logic [V_W-1:0] vdc_i,
  input  logic [G_W-1:0] kp_i,
  input  logic [G_W-1:0] ki_i,
  input  logic [D_W-1:0] dmax_i,
  output logic [D_W-1:0] u_o
);
  localparam int unsigned E_W = V_W + 1;
  localparam int unsigned P_W = E_W + G_W + 4;

  logic signed [E_W-1:0] err, e_prev_q;
  logic signed [E_W:0]   derr;
  logic signed [P_W-1:0] prod_p, prod_i, inc, u_sum, lim;
  logic [D_W-1:0]        u_q, u_nxt;

  always_comb begin
    err    = $signed({1'b0, vref_i}) - $signed({1'b0, vdc_i});
    derr   = $signed({err[E_W-1], err}) - $signed({e_prev_q[E_W-1], e_prev_q});
    prod_p = P_W'(derr) * $signed(P_W'({1'b0, kp_i}));
    prod_i = P_W'(err)  * $signed(P_W'({1'b0, ki_i}));
    inc    = (prod_p + prod_i) >>> G_FRAC;
    u_sum  = inc + $signed(P_W'({1'b0, u_q}));
    lim    = $signed(P_W'({1'b0, dmax_i}));
    if (u_sum < 0)        u_nxt = '0;
    else if (u_sum > lim) u_nxt = dmax_i;
    else                  u_nxt = D_W'(u_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q      <= '0;
      e_prev_q <= '0;
    end else if (!en_i) begin
      u_q      <= '0;
      e_prev_q <= '0;
    end else if (strobe_i) begin
      u_q      <= u_nxt;
      e_prev_q <= err;
    end
  end

  assign u_o = u_q;

  assert_clear_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (u_o == '0));
  assert_anti_windup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && strobe_i) |=> (u_o <= $past(dmax_i)));
endmodule

// File: rtl/pfc_thd_shaper.sv
module pfc_thd_shaper
  import pfc_pkg::*;
#(
  parameter int unsigned V_W = 12,
  parameter int unsigned D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           strobe_i,
  input  logic [V_W-1:0] vin_i,
  input  logic [V_W-1:0] vref_i,
  input  logic [D_W-1:0] u_i,
  output logic [D_W-1:0] duty_o
);
  localparam int unsigned N_W = V_W + C_FRAC;
  localparam int unsigned R_W = C_FRAC + 1;
  localparam int unsigned X_W = D_W + R_W;
  localparam logic [R_W-1:0] ONE = R_W'(1 << C_FRAC);

  logic [V_W-1:0] vin_q, vref_q, vmin;
  logic [N_W-1:0] num, den, quo;
  logic [R_W-1:0] ratio, corr;
  logic [X_W-1:0] prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vin_q  <= '0;
      vref_q <= '0;
    end else if (strobe_i) begin
      vin_q  <= vin_i;
      vref_q <= vref_i;
    end
  end

  always_comb begin
    vmin  = (vin_q < vref_q) ? vin_q : vref_q;
    num   = {vmin, {C_FRAC{1'b0}}};
    den   = N_W'(vref_q);
    quo   = (vref_q == '0) ? '0 : num / den;
    ratio = R_W'(quo);
    corr  = ONE - (ratio >> 1);
    prod  = (X_W'(u_i) * X_W'(corr)) >> C_FRAC;
    duty_o = D_W'(prod);
  end

  assert_corr_no_gain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o <= u_i);
endmodule

// File: rtl/pfc_pwm_gen.sv
module pfc_pwm_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] duty_next_i,
  output logic             sample_o,
  output logic             gate_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int unsigned PERIOD = 1 << CNT_W;
  localparam logic [CNT_W-1:0] SMP_CNT  = CNT_W'(PERIOD - 2);
  localparam logic [CNT_W-1:0] WRAP_CNT = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                duty_q <= '0;
    else if (!en_i)             duty_q <= '0;
    else if (cnt_q == WRAP_CNT) duty_q <= duty_next_i;
  end

  assign sample_o = (cnt_q == SMP_CNT);
  assign gate_o   = en_i & (cnt_q < duty_q);
  assign duty_o   = duty_q;

  assert_no_midperiod_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && cnt_q != '0) |-> $stable(duty_q));
  assert_strobe_before_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (cnt_q == WRAP_CNT));
endmodule

// File: rtl/pfc_duty_ctrl.sv
module pfc_duty_ctrl #(
  parameter int unsigned SPD_W = 12,
  parameter int unsigned KV_W  = 12,
  parameter int unsigned V_W   = 12,
  parameter int unsigned G_W   = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SPD_W-1:0] speed_ref_i,
  input  logic [KV_W-1:0]  kv_i,
  input  logic [V_W-1:0]   vdc_i,
  input  logic [V_W-1:0]   vin_i,
  input  logic [G_W-1:0]   kp_i,
  input  logic [G_W-1:0]   ki_i,
  input  logic [CNT_W-1:0] dmax_i,
  output logic             sample_o,
  output logic             gate_o,
  output logic [CNT_W-1:0] duty_o
);
  logic [V_W-1:0]   vref;
  logic [CNT_W-1:0] u, duty_next;

  pfc_vref_gen #(.SPD_W(SPD_W), .KV_W(KV_W), .V_W(V_W)) u_vref (
    .speed_i(speed_ref_i), .kv_i(kv_i), .vref_o(vref)
  );

  pfc_pi_incr #(.V_W(V_W), .G_W(G_W), .D_W(CNT_W)) u_pi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .strobe_i(sample_o),
    .vref_i(vref), .vdc_i(vdc_i), .kp_i(kp_i), .ki_i(ki_i),
    .dmax_i(dmax_i), .u_o(u)
  );

  pfc_thd_shaper #(.V_W(V_W), .D_W(CNT_W)) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(sample_o),
    .vin_i(vin_i), .vref_i(vref), .u_i(u), .duty_o(duty_next)
  );

  pfc_pwm_gen #(.CNT_W(CNT_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .duty_next_i(duty_next),
    .sample_o(sample_o), .gate_o(gate_o), .duty_o(duty_o)
  );

  assert_gate_needs_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (duty_o != '0));
endmodule

// File: tb/pfc_duty_ctrl_tb.sv
module pfc_duty_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 256;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [11:0] spd = '0, kv = '0, vdc = '0, vin = '0;
  logic [7:0]  kp = '0, ki = '0, dmax = '0;
  logic sample, gate;
  logic [7:0] duty;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_duty_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .speed_ref_i(spd), .kv_i(kv),
    .vdc_i(vdc), .vin_i(vin), .kp_i(kp), .ki_i(ki), .dmax_i(dmax),
    .sample_o(sample), .gate_o(gate), .duty_o(duty)
  );

  int n_chk = 0, n_err = 0;
  int m_u = 0, m_ep = 0, m_pend = 0, m_duty = 0, m_dmax_s = 0;
  // next-period stimulus
  int nx_en = 0, nx_spd = 0, nx_kv = 0, nx_vdc = 0, nx_vin = 0, nx_kp = 0, nx_ki = 0, nx_dmax = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_vref(int k, int s);
    int v = (k * s) >>> 8;
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic model_sample();
    int vr, e, inc, s, mn, ratio, c;
    m_dmax_s = int'(dmax);
    if (!en) begin
      m_u = 0; m_ep = 0; m_pend = 0;
    end else begin
      vr  = f_vref(int'(kv), int'(spd));
      e   = vr - int'(vdc);
      inc = (int'(kp) * (e - m_ep) + int'(ki) * e) >>> 4;
      s   = m_u + inc;
      if (s < 0) s = 0;
      else if (s > int'(dmax)) s = int'(dmax);
      m_u = s; m_ep = e;
      mn    = (int'(vin) < vr) ? int'(vin) : vr;
      ratio = (vr == 0) ? 0 : (mn * 256) / vr;
      c     = 256 - (ratio >>> 1);
      m_pend = (m_u * c) >>> 8;
    end
  endtask

  task automatic drive_next();
    en = nx_en[0]; spd = 12'(nx_spd); kv = 12'(nx_kv); vdc = 12'(nx_vdc);
    vin = 12'(nx_vin); kp = 8'(nx_kp); ki = 8'(nx_ki); dmax = 8'(nx_dmax);
  endtask

  // bench is aligned so that loop index i equals the counter value
  task automatic run_period(string tag);
    int hi = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk({tag, " R6 latched duty"}, int'(duty), m_duty);
        chk({tag, " R5 duty within ceiling"}, int'(duty <= 8'(m_dmax_s)), 1);
      end
      if (gate) hi++;
      if (i == PER-2) begin
        chk({tag, " R6 strobe"}, int'(sample), 1);
        model_sample();
      end
      if (i == PER-1) begin
        chk({tag, " R7 gate width"}, hi, m_duty);
        drive_next();
        if (!en) begin m_u = 0; m_ep = 0; m_duty = 0; end
        else m_duty = m_pend;
      end
    end
  endtask

  task automatic set_nx(int e, int s, int k, int vd, int vi, int p, int q, int dm);
    nx_en = e; nx_spd = s; nx_kv = k; nx_vdc = vd; nx_vin = vi; nx_kp = p; nx_ki = q; nx_dmax = dm;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int vr;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    chk("R9 gate after reset", int'(gate), 0);
    chk("R9 duty after reset", int'(duty), 0);
    chk("R9 strobe after reset", int'(sample), 0);
    rst_n = 1'b1;
    do @(negedge clk); while (!sample);
    @(negedge clk);
    set_nx(1, 1200, 34, 140, 100, 8, 4, 230);
    drive_next();
    m_duty = 0; m_u = 0; m_ep = 0;

    // R1 R2: 1200 rpm, link lagging then approaching
    for (int n = 0; n < 8; n++) begin
      vr = f_vref(34, 1200);
      set_nx(1, 1200, 34, vr - 20 + n * 3, 60 + n * 10, 8, 4, 230);
      run_period("R1 R2 1200rpm");
    end
    // R1 R2: step to 1500 rpm
    for (int n = 0; n < 10; n++) begin
      vr = f_vref(34, 1500);
      set_nx(1, 1500, 34, vr - 40 + n * 4, 120, 12, 6, 230);
      run_period("R1 R2 step 1500rpm");
    end
    // R3: ceiling
    for (int n = 0; n < 6; n++) begin
      set_nx(1, 1500, 34, 0, 0, 40, 20, 200);
      run_period("R3 saturate high");
    end
    chk("R3 stuck at ceiling", m_duty, 200);
    // R3: floor
    for (int n = 0; n < 6; n++) begin
      set_nx(1, 1500, 34, 4095, 0, 40, 20, 200);
      run_period("R3 saturate low");
    end
    chk("R3 at floor", int'(duty), 0);
    // R4: vref zero -> unity factor, then vin above vref -> half factor
    for (int n = 0; n < 3; n++) begin
      set_nx(1, 1500, 34, 0, 50, 40, 20, 180);
      run_period("R4 prime");
    end
    for (int n = 0; n < 3; n++) begin
      set_nx(1, 1500, 0, 0, 50, 0, 0, 180);
      run_period("R4 vref zero");
    end
    for (int n = 0; n < 4; n++) begin
      set_nx(1, 1500, 34, 199, 4000, 0, 0, 180);
      run_period("R4 vin above vref");
    end
    // R8: disable then re-enable
    for (int n = 0; n < 3; n++) begin
      set_nx(0, 1500, 34, 0, 100, 40, 20, 200);
      run_period("R8 disabled");
      chk("R8 gate low when off", int'(gate), 0);
    end
    for (int n = 0; n < 4; n++) begin
      set_nx(1, 1500, 34, 150, 100, 20, 10, 200);
      run_period("R8 re-enabled");
    end
    // R1: target saturation
    for (int n = 0; n < 3; n++) begin
      set_nx(1, 4095, 4095, 4000, 3000, 10, 5, 220);
      run_period("R1 vref saturation");
    end
    // random mix
    for (int n = 0; n < 60; n++) begin
      int s = ($urandom % 2) ? 1500 : 1200;
      int k = 20 + int'($urandom % 30);
      vr = f_vref(k, s);
      set_nx(($urandom % 10) != 0, s, k, vr - 60 + int'($urandom % 120),
             int'($urandom % (vr + 40)), 1 + int'($urandom % 48),
             1 + int'($urandom % 24), 120 + int'($urandom % 130));
      run_period("R2 R4 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule